// File: doc/BRIEF.md
# SD host SDMA transfer engine

This block is the simple-DMA data mover of an SD host controller, seen through its programming registers. Software loads a system memory address, a block size with a boundary code, a block count and a host control byte. A write to the transfer mode register then starts the transfer. The engine moves bytes between a memory-side request/grant port and a card-side byte stream. Bit 4 of the mode word sets the direction: card to memory, or memory to card.

The address counts up by one per byte. The boundary size is 4 KiB shifted left by the boundary code. When the next address falls on a multiple of that size and bytes are still left, the engine stops, holds its ports quiet and raises the DMA interrupt status bit. Software reads the address register, which holds the next address to be accessed, and writes a value back to it. The engine then continues from that value.

When the last byte of the last block is accepted, the engine raises transfer complete. A card error aborts the transfer and raises an error status bit. Status bits are cleared by writing 1 to them. A status bit can be set only while its enable bit is set.

Top module: `sdma_engine`

## Requirements
- R1: After reset every register reads 0, `irq_o` is low and no memory request, card receive-ready or card transmit-valid is driven.
- R2: A transfer starts only on a mode-register write that meets all of these conditions: the engine is idle, bit 0 of the written mode word is 1, the host-control DMA select bits [4:3] read 00, the block size (bits [11:0] of the block size register) is non-zero, and, when counting is selected, the block count is non-zero. A mode write that fails any condition starts nothing.
- R3: With mode bit 4 = 1, bytes from the card stream are written to memory at consecutive addresses, beginning at the system address.
- R4: With mode bit 4 = 0, bytes are read from memory at consecutive addresses and presented to the card in address order. A memory request holds its address until it is granted.
- R5: When mode bit 1 (count enable) and mode bit 5 (multi-block) are both 1, the block count register sets the number of blocks and reads back the blocks still to move. Otherwise exactly one block moves, the count register is loaded with 1, and the register reads 0 once the block is done.
- R6: The boundary size is 4 KiB << code, where the code is bits [14:12] of the block size register. If the next address is a multiple of the boundary size and bytes remain, the engine pauses, sets status bit 3 and drives no requests.
- R7: The system address register reads back the next address. In a pause, writing it resumes the transfer from the written address.
- R8: Acceptance of the final byte sets status bit 1 and returns the engine to idle. A final byte that lands on a boundary does not set bit 3.
- R9: Writing 1 to a status bit clears it, and writing 0 leaves it unchanged. A status bit is set only when the matching bit of the status enable register is 1.
- R10: An assertion of `card_err_i` during a transfer aborts it, sets status bit 15 and does not set bit 1.
- R11: When mode bits 2 and 5 are both 1, `acmd12_o` pulses for one cycle as the transfer completes. Otherwise it stays low.
- R12: While a transfer is active, writes to the block size, block count, mode and host control registers are ignored. Writes to the address register are ignored except during a pause.
- R13: `irq_o` is high exactly when any status bit is set.

Register select values: 0 address, 1 block size, 2 block count, 3 mode, 4 host control, 5 status, 6 status enable, 7 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_wr_i | input | 1 | Register write strobe |
| reg_sel_i | input | 3 | Register select |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Read data of the selected register (combinational) |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Memory request is a write |
| mem_addr_o | output | ADDR_W | Memory byte address |
| mem_wdata_o | output | DATA_W | Memory write byte |
| mem_gnt_i | input | 1 | Memory grant; read data is valid with it |
| mem_rdata_i | input | DATA_W | Memory read byte |
| card_rx_valid_i | input | 1 | Card byte available |
| card_rx_data_i | input | DATA_W | Card byte |
| card_rx_ready_o | output | 1 | Engine takes a card byte |
| card_tx_valid_o | output | 1 | Byte offered to the card |
| card_tx_data_o | output | DATA_W | Byte to the card |
| card_tx_ready_i | input | 1 | Card takes the byte |
| card_err_i | input | 1 | Card-side error |
| acmd12_o | output | 1 | Request for an automatic stop command |
| irq_o | output | 1 | Any status bit set |

## Verification
A register write takes effect at the clock edge that ends its cycle. Reads are combinational, so the bench reads every register at the falling edge after a write. Status bits 1, 3 and 15 and the `acmd12_o` pulse appear at the edge that accepts the final byte, the boundary byte or the error. The bench polls the status register at falling edges and compares memory contents and the card stream against sequences it generated itself. Handshakes are decided and logged at the falling edge before the accepting rising edge, so every expected byte is known before the engine consumes it.

// File: rtl/sdma_pkg.sv
package sdma_pkg;
  localparam int SIZE_W    = 12;
  localparam int CODE_W    = 3;
  localparam int BND_CODES = 8;
  localparam int STAT_W    = 16;
  localparam int MODE_W    = 6;

  localparam logic [2:0] RS_ADDR  = 3'd0;
  localparam logic [2:0] RS_BSIZE = 3'd1;
  localparam logic [2:0] RS_BCNT  = 3'd2;
  localparam logic [2:0] RS_MODE  = 3'd3;
  localparam logic [2:0] RS_HCTL  = 3'd4;
  localparam logic [2:0] RS_STAT  = 3'd5;
  localparam logic [2:0] RS_STEN  = 3'd6;

  localparam int MB_DMA   = 0;
  localparam int MB_CNT   = 1;
  localparam int MB_ACMD  = 2;
  localparam int MB_DIR   = 4;
  localparam int MB_MULTI = 5;

  localparam int SB_XC  = 1;
  localparam int SB_DMA = 3;
  localparam int SB_ERR = 15;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_GET   = 2'd1,
    ST_PUT   = 2'd2,
    ST_PAUSE = 2'd3
  } xfer_state_e;

  typedef struct packed {
    logic [CODE_W-1:0] code;
    logic [SIZE_W-1:0] size;
  } bsize_t;
endpackage

// File: rtl/sdma_bnd_detect.sv
module sdma_bnd_detect #(
  parameter int BASE_LOG2 = 12,
  parameter int NCODE     = 8,
  localparam int CODE_W   = $clog2(NCODE),
  localparam int LOW_W    = BASE_LOG2 + NCODE - 1
) (
  input  logic [LOW_W-1:0]  addr_i,
  input  logic [CODE_W-1:0] code_i,
  output logic              hit_o
);
  logic [NCODE-1:0] hit_vec;

  // one alignment test per boundary code
  for (genvar c = 0; c < NCODE; c++) begin : g_code
    assign hit_vec[c] = ~|addr_i[BASE_LOG2+c-1:0];
  end

  assign hit_o = hit_vec[code_i];
endmodule

// File: rtl/sdma_xfer_cnt.sv
module sdma_xfer_cnt #(
  parameter int SIZE_W = 12,
  parameter int CNT_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [CNT_W-1:0]  load_blocks_i,
  input  logic              sw_wr_i,
  input  logic [CNT_W-1:0]  sw_data_i,
  input  logic              step_i,
  input  logic [SIZE_W-1:0] size_i,
  output logic [CNT_W-1:0]  blocks_o,
  output logic              last_o
);
  logic [SIZE_W-1:0] byte_q;
  logic [CNT_W-1:0]  blocks_q;
  logic              blk_end;

  assign blk_end  = (byte_q == (size_i - SIZE_W'(1)));
  assign last_o   = blk_end && (blocks_q == CNT_W'(1));
  assign blocks_o = blocks_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      byte_q   <= '0;
      blocks_q <= '0;
    end else if (load_i) begin
      byte_q   <= '0;
      blocks_q <= load_blocks_i;
    end else if (step_i) begin
      if (blk_end) begin
        byte_q   <= '0;
        blocks_q <= blocks_q - CNT_W'(1);
      end else begin
        byte_q   <= byte_q + SIZE_W'(1);
      end
    end else if (sw_wr_i) begin
      blocks_q <= sw_data_i;
    end
  end
endmodule

// File: rtl/sdma_irq_stat.sv
module sdma_irq_stat #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] en_i,
  input  logic         clr_wr_i,
  input  logic [W-1:0] clr_data_i,
  output logic [W-1:0] stat_o
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    logic q;
    // a new event wins over a same-cycle clear
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                       q <= 1'b0;
      else if (set_i[b] && en_i[b])      q <= 1'b1;
      else if (clr_wr_i && clr_data_i[b]) q <= 1'b0;
    end
    assign stat_o[b] = q;
  end
endmodule

// File: rtl/sdma_engine.sv
module sdma_engine
  import sdma_pkg::*;
#(
  parameter int ADDR_W        = 32,
  parameter int DATA_W        = 8,
  parameter int CNT_W         = 16,
  parameter int BND_BASE_LOG2 = 12,
  localparam int LOW_W        = BND_BASE_LOG2 + BND_CODES - 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_wr_i,
  input  logic [2:0]        reg_sel_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic              mem_gnt_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  input  logic              card_rx_valid_i,
  input  logic [DATA_W-1:0] card_rx_data_i,
  output logic              card_rx_ready_o,
  output logic              card_tx_valid_o,
  output logic [DATA_W-1:0] card_tx_data_o,
  input  logic              card_tx_ready_i,
  input  logic              card_err_i,
  output logic              acmd12_o,
  output logic              irq_o
);
  xfer_state_e       state_q, state_d;
  logic [ADDR_W-1:0] addr_q, addr_nxt;
  bsize_t            bsize_q;
  logic [MODE_W-1:0] mode_q;
  logic [7:0]        hctl_q;
  logic [STAT_W-1:0] sten_q, stat_q, stat_set;
  logic [DATA_W-1:0] data_q;
  logic [CNT_W-1:0]  blocks;
  logic              acmd_q;

  logic wr_addr, wr_bsize, wr_bcnt, wr_mode, wr_hctl, wr_stat, wr_sten;
  logic active, moving, dir_rd, use_cnt, start;
  logic get_fire, put_fire, last, bnd_hit, err_evt, done_ok, pause_ok;

  assign wr_addr  = reg_wr_i && (reg_sel_i == RS_ADDR);
  assign wr_bsize = reg_wr_i && (reg_sel_i == RS_BSIZE);
  assign wr_bcnt  = reg_wr_i && (reg_sel_i == RS_BCNT);
  assign wr_mode  = reg_wr_i && (reg_sel_i == RS_MODE);
  assign wr_hctl  = reg_wr_i && (reg_sel_i == RS_HCTL);
  assign wr_stat  = reg_wr_i && (reg_sel_i == RS_STAT);
  assign wr_sten  = reg_wr_i && (reg_sel_i == RS_STEN);

  assign active = (state_q != ST_IDLE);
  assign moving = (state_q == ST_GET) || (state_q == ST_PUT);
  assign dir_rd = mode_q[MB_DIR];

  // counting honoured only with both count-enable and multi-block
  assign use_cnt = reg_wdata_i[MB_CNT] && reg_wdata_i[MB_MULTI];
  assign start   = wr_mode && !active && reg_wdata_i[MB_DMA]
                && (hctl_q[4:3] == 2'b00)
                && (bsize_q.size != '0)
                && (!use_cnt || (blocks != '0));

  assign get_fire = (state_q == ST_GET) && (dir_rd ? card_rx_valid_i : mem_gnt_i);
  assign put_fire = (state_q == ST_PUT) && (dir_rd ? mem_gnt_i : card_tx_ready_i);
  assign err_evt  = card_err_i && active;
  assign addr_nxt = addr_q + ADDR_W'(1);
  assign done_ok  = put_fire && last && !err_evt;
  assign pause_ok = put_fire && !last && bnd_hit && !err_evt;

  sdma_bnd_detect #(
    .BASE_LOG2 (BND_BASE_LOG2),
    .NCODE     (BND_CODES)
  ) u_bnd (
    .addr_i (addr_nxt[LOW_W-1:0]),
    .code_i (bsize_q.code),
    .hit_o  (bnd_hit)
  );

  sdma_xfer_cnt #(
    .SIZE_W (SIZE_W),
    .CNT_W  (CNT_W)
  ) u_cnt (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .load_i        (start),
    .load_blocks_i (use_cnt ? blocks : CNT_W'(1)),
    .sw_wr_i       (wr_bcnt && !active),
    .sw_data_i     (reg_wdata_i[CNT_W-1:0]),
    .step_i        (put_fire && !err_evt),
    .size_i        (bsize_q.size),
    .blocks_o      (blocks),
    .last_o        (last)
  );

  always_comb begin
    stat_set         = '0;
    stat_set[SB_XC]  = done_ok;
    stat_set[SB_DMA] = pause_ok;
    stat_set[SB_ERR] = err_evt;
  end

  sdma_irq_stat #(
    .W (STAT_W)
  ) u_stat (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .set_i      (stat_set),
    .en_i       (sten_q),
    .clr_wr_i   (wr_stat),
    .clr_data_i (reg_wdata_i[STAT_W-1:0]),
    .stat_o     (stat_q)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (start) state_d = ST_GET;
      ST_GET:   if (get_fire) state_d = ST_PUT;
      ST_PUT:   if (put_fire) state_d = last ? ST_IDLE : (bnd_hit ? ST_PAUSE : ST_GET);
      ST_PAUSE: if (wr_addr) state_d = ST_GET;
      default:  state_d = ST_IDLE;
    endcase
    if (err_evt) state_d = ST_IDLE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      bsize_q <= '0;
      mode_q  <= '0;
      hctl_q  <= '0;
      sten_q  <= '0;
      data_q  <= '0;
      acmd_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      if (wr_addr && !moving)       addr_q <= reg_wdata_i[ADDR_W-1:0];
      else if (put_fire && !err_evt) addr_q <= addr_nxt;
      if (wr_bsize && !active) bsize_q <= reg_wdata_i[SIZE_W+CODE_W-1:0];
      if (wr_mode && !active)  mode_q  <= reg_wdata_i[MODE_W-1:0];
      if (wr_hctl && !active)  hctl_q  <= reg_wdata_i[7:0];
      if (wr_sten)             sten_q  <= reg_wdata_i[STAT_W-1:0];
      if (get_fire)            data_q  <= dir_rd ? card_rx_data_i : mem_rdata_i;
      acmd_q <= done_ok && mode_q[MB_ACMD] && mode_q[MB_MULTI];
    end
  end

  assign mem_req_o       = ((state_q == ST_GET) && !dir_rd) || ((state_q == ST_PUT) && dir_rd);
  assign mem_we_o        = (state_q == ST_PUT) && dir_rd;
  assign mem_addr_o      = addr_q;
  assign mem_wdata_o     = data_q;
  assign card_rx_ready_o = (state_q == ST_GET) && dir_rd;
  assign card_tx_valid_o = (state_q == ST_PUT) && !dir_rd;
  assign card_tx_data_o  = data_q;
  assign acmd12_o        = acmd_q;
  assign irq_o           = |stat_q;

  always_comb begin
    unique case (reg_sel_i)
      RS_ADDR:  reg_rdata_o = 32'(addr_q);
      RS_BSIZE: reg_rdata_o = 32'(bsize_q);
      RS_BCNT:  reg_rdata_o = 32'(blocks);
      RS_MODE:  reg_rdata_o = 32'(mode_q);
      RS_HCTL:  reg_rdata_o = 32'(hctl_q);
      RS_STAT:  reg_rdata_o = 32'(stat_q);
      RS_STEN:  reg_rdata_o = 32'(sten_q);
      default:  reg_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/sdma_engine_chk.sv
module sdma_engine_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              mem_req_i,
  input logic              mem_we_i,
  input logic              mem_gnt_i,
  input logic [ADDR_W-1:0] mem_addr_i,
  input logic              rx_ready_i,
  input logic              tx_valid_i,
  input logic              card_err_i,
  input logic              acmd12_i,
  input logic              stat_xc_i,
  input logic              stat_dma_i,
  input logic              stat_err_i,
  input logic              clr_xc_i,
  input logic              clr_err_i
);
  assert_one_side_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_req_i && (rx_ready_i || tx_valid_i)));

  assert_req_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_i && !mem_gnt_i && !card_err_i |=> mem_req_i && $stable(mem_addr_i) && $stable(mem_we_i));

  assert_pause_quiet_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(stat_dma_i) |-> !mem_req_i && !rx_ready_i && !tx_valid_i);

  assert_done_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(stat_xc_i) |-> !mem_req_i && !rx_ready_i && !tx_valid_i);

  assert_sticky_xc_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_xc_i && !clr_xc_i |=> stat_xc_i);

  assert_sticky_err_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_err_i && !clr_err_i |=> stat_err_i);

  assert_err_stop_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(stat_err_i) |-> !mem_req_i && !rx_ready_i && !tx_valid_i);

  assert_acmd_pulse_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acmd12_i |=> !acmd12_i);
endmodule

bind sdma_engine sdma_engine_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .mem_req_i  (mem_req_o),
  .mem_we_i   (mem_we_o),
  .mem_gnt_i  (mem_gnt_i),
  .mem_addr_i (mem_addr_o),
  .rx_ready_i (card_rx_ready_o),
  .tx_valid_i (card_tx_valid_o),
  .card_err_i (card_err_i),
  .acmd12_i   (acmd12_o),
  .stat_xc_i  (stat_q[1]),
  .stat_dma_i (stat_q[3]),
  .stat_err_i (stat_q[15]),
  .clr_xc_i   (reg_wr_i && (reg_sel_i == 3'd5) && reg_wdata_i[1]),
  .clr_err_i  (reg_wr_i && (reg_sel_i == 3'd5) && reg_wdata_i[15])
);

// File: tb/sdma_engine_tb_top.sv
module sdma_engine_tb_top;
  localparam logic [2:0] S_ADDR = 3'd0, S_BSIZE = 3'd1, S_BCNT = 3'd2, S_MODE = 3'd3,
                         S_HCTL = 3'd4, S_STAT = 3'd5, S_STEN = 3'd6;
  localparam logic [31:0] M_DMA = 32'h1, M_CNT = 32'h2, M_ACMD = 32'h4, M_RD = 32'h10, M_MULTI = 32'h20;

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [2:0] reg_sel = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic mem_req, mem_we, mem_gnt = 1'b0;
  logic [31:0] mem_addr;
  logic [7:0] mem_wdata, mem_rdata = '0;
  logic rx_valid = 1'b0, rx_ready, tx_valid, tx_ready = 1'b0, card_err = 1'b0, acmd12, irq;
  logic [7:0] rx_data = '0, tx_data;

  int checks = 0, errors = 0;
  int rx_idx = 0, tx_idx = 0, acmd_cnt = 0, act_cnt = 0;
  logic [7:0] mem_m [0:65535];
  logic [7:0] rx_seq [0:255];
  logic [7:0] tx_cap [0:255];

  always #10 clk = ~clk;

  sdma_engine dut_i (
    .clk_i (clk), .rst_ni (rst_n),
    .reg_wr_i (reg_wr), .reg_sel_i (reg_sel), .reg_wdata_i (reg_wdata), .reg_rdata_o (reg_rdata),
    .mem_req_o (mem_req), .mem_we_o (mem_we), .mem_addr_o (mem_addr), .mem_wdata_o (mem_wdata),
    .mem_gnt_i (mem_gnt), .mem_rdata_i (mem_rdata),
    .card_rx_valid_i (rx_valid), .card_rx_data_i (rx_data), .card_rx_ready_o (rx_ready),
    .card_tx_valid_o (tx_valid), .card_tx_data_o (tx_data), .card_tx_ready_i (tx_ready),
    .card_err_i (card_err), .acmd12_o (acmd12), .irq_o (irq)
  );

  function automatic logic [7:0] pat(input logic [31:0] a);
    return a[7:0] ^ a[15:8] ^ 8'hA5;
  endfunction

  function automatic logic [31:0] bsz(input int code, input int size);
    return (32'(code) << 12) | 32'(size);
  endfunction

  // memory and card models: handshakes decided and logged at the falling edge
  always @(negedge clk) begin
    mem_gnt = 1'b0; rx_valid = 1'b0; tx_ready = 1'b0;
    if (mem_req || rx_ready || tx_valid) act_cnt++;
    if (acmd12) acmd_cnt++;
    if (mem_req && ($urandom % 4 != 0)) begin
      mem_gnt = 1'b1;
      if (mem_we) mem_m[mem_addr[15:0]] = mem_wdata;
      else mem_rdata = pat(mem_addr);
    end
    if (rx_ready && ($urandom % 3 != 0)) begin
      rx_valid = 1'b1; rx_data = rx_seq[rx_idx[7:0]]; rx_idx++;
    end
    if (tx_valid && ($urandom % 3 != 0)) begin
      tx_ready = 1'b1; tx_cap[tx_idx[7:0]] = tx_data; tx_idx++;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] s, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_sel = s; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] s, output logic [31:0] v);
    reg_sel = s; #1; v = reg_rdata;
  endtask

  task automatic wait_stat(input logic [31:0] mask);
    logic [31:0] v;
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk); rd(S_STAT, v);
      if ((v & mask) != 0) break;
    end
  endtask

  task automatic setup(input logic [31:0] a, input logic [31:0] bs, input logic [31:0] bc);
    wr(S_ADDR, a); wr(S_BSIZE, bs); wr(S_BCNT, bc);
    rx_idx = 0; tx_idx = 0; acmd_cnt = 0;
    for (int i = 0; i < 256; i++) rx_seq[i] = 8'($urandom);
  endtask

  task automatic quiet(input int n, input string tag);
    act_cnt = 0;
    repeat (n) @(negedge clk);
    check(tag, 32'(act_cnt), 32'd0);
  endtask

  initial begin
    logic [31:0] v;
    void'($urandom(32'h5EED_0042));
    for (int i = 0; i < 65536; i++) mem_m[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int s = 0; s < 8; s++) begin rd(3'(s), v); check("R1 reg reset", v, 32'h0); end
    check("R1 irq reset", {31'b0, irq}, 32'h0);
    check("R1 no activity", {29'b0, mem_req, rx_ready, tx_valid}, 32'h0);

    wr(S_STEN, 32'h800A);

    // R3 single read block, count disabled
    setup(32'h100, bsz(7, 16), 32'h0);
    wr(S_MODE, M_DMA | M_RD);
    wait_stat(32'h2);
    for (int i = 0; i < 16; i++) check("R3 mem byte", 32'(mem_m[16'h100 + i]), 32'(rx_seq[i]));
    rd(S_ADDR, v); check("R7 next addr", v, 32'h110);
    rd(S_BCNT, v); check("R5 count after one block", v, 32'h0);
    rd(S_STAT, v); check("R8 complete bit", v, 32'h2);
    check("R13 irq high", {31'b0, irq}, 32'h1);
    wr(S_STAT, 32'h8); rd(S_STAT, v); check("R9 write 1 to clear bit only", v, 32'h2);
    wr(S_STAT, 32'h2); rd(S_STAT, v); check("R9 cleared", v, 32'h0);
    check("R13 irq low", {31'b0, irq}, 32'h0);

    // R4 R5 R11 multi-block memory to card
    setup(32'h2000, bsz(7, 5), 32'd3);
    wr(S_MODE, M_DMA | M_CNT | M_ACMD | M_MULTI);
    @(negedge clk); @(negedge clk);
    rd(S_BCNT, v); check("R5 count live", {31'b0, (v == 32'd3 || v == 32'd2)}, 32'h1);
    wait_stat(32'h2);
    repeat (2) @(negedge clk);
    check("R4 byte count", 32'(tx_idx), 32'd15);
    for (int i = 0; i < 15; i++) check("R4 card byte", 32'(tx_cap[i]), 32'(pat(32'h2000 + 32'(i))));
    rd(S_BCNT, v); check("R5 count end", v, 32'h0);
    check("R11 auto stop pulse", 32'(acmd_cnt), 32'd1);
    wr(S_STAT, 32'hFFFF);

    // R5 count enable without multi-block: one block; R11 no pulse
    setup(32'h2100, bsz(7, 4), 32'd3);
    wr(S_MODE, M_DMA | M_CNT | M_ACMD);
    wait_stat(32'h2);
    repeat (2) @(negedge clk);
    check("R5 single block bytes", 32'(tx_idx), 32'd4);
    check("R11 no pulse single", 32'(acmd_cnt), 32'd0);
    wr(S_STAT, 32'hFFFF);

    // R6 R7 R12 boundary pause at 4 KiB
    setup(32'h0FFC, bsz(0, 8), 32'h0);
    wr(S_MODE, M_DMA | M_RD);
    wait_stat(32'hA);
    rd(S_STAT, v); check("R6 dma bit", v, 32'h8);
    rd(S_ADDR, v); check("R7 pause addr", v, 32'h1000);
    quiet(10, "R6 paused quiet");
    wr(S_BSIZE, 32'h40); rd(S_BSIZE, v); check("R12 size locked", v, 32'h8);
    wr(S_STAT, 32'h8);
    wr(S_ADDR, 32'h1000);
    wait_stat(32'hA);
    rd(S_STAT, v); check("R8 complete after resume", v, 32'h2);
    for (int i = 0; i < 8; i++) check("R7 resumed bytes", 32'(mem_m[16'h0FFC + i]), 32'(rx_seq[i]));
    wr(S_STAT, 32'hFFFF);

    // R6 code 1: no pause at 4 KiB, pause at 8 KiB
    setup(32'h0FFE, bsz(1, 4), 32'h0);
    wr(S_MODE, M_DMA | M_RD);
    wait_stat(32'hA);
    rd(S_STAT, v); check("R6 no pause off 8K", v, 32'h2);
    wr(S_STAT, 32'hFFFF);
    setup(32'h1FFE, bsz(1, 4), 32'h0);
    wr(S_MODE, M_DMA | M_RD);
    wait_stat(32'hA);
    rd(S_STAT, v); check("R6 pause at 8K", v, 32'h8);
    rd(S_ADDR, v); check("R6 pause addr 8K", v, 32'h2000);
    wr(S_STAT, 32'h8); wr(S_ADDR, 32'h2000);
    wait_stat(32'hA);
    rd(S_STAT, v); check("R7 resume completes", v, 32'h2);
    wr(S_STAT, 32'hFFFF);

    // R8 last byte on boundary
    setup(32'h0FF8, bsz(0, 8), 32'h0);
    wr(S_MODE, M_DMA | M_RD);
    wait_stat(32'hA);
    rd(S_STAT, v); check("R8 last on boundary", v, 32'h2);
    wr(S_STAT, 32'hFFFF);

    // R2 rejected starts
    wr(S_HCTL, 32'h10);
    setup(32'h300, bsz(7, 4), 32'h0);
    wr(S_MODE, M_DMA | M_RD);
    quiet(20, "R2 ADMA select");
    wr(S_HCTL, 32'h0);
    wr(S_BSIZE, bsz(7, 0));
    wr(S_MODE, M_DMA | M_RD);
    quiet(20, "R2 zero size");
    wr(S_BSIZE, bsz(7, 4)); wr(S_BCNT, 32'h0);
    wr(S_MODE, M_DMA | M_CNT | M_MULTI | M_RD);
    quiet(20, "R2 zero count");
    wr(S_MODE, M_RD);
    quiet(20, "R2 dma bit clear");
    rd(S_ADDR, v); check("R2 addr unchanged", v, 32'h300);

    // R9 disabled complete bit
    wr(S_STEN, 32'h8008);
    setup(32'h400, bsz(7, 4), 32'h0);
    wr(S_MODE, M_DMA | M_RD);
    for (int i = 0; i < 5000; i++) begin @(negedge clk); rd(S_ADDR, v); if (v == 32'h404) break; end
    repeat (3) @(negedge clk);
    rd(S_STAT, v); check("R9 enable gates set", v, 32'h0);
    check("R13 irq stays low", {31'b0, irq}, 32'h0);
    wr(S_STEN, 32'h800A);

    // R10 card error abort
    setup(32'h600, bsz(7, 16), 32'd4);
    wr(S_MODE, M_DMA | M_CNT | M_MULTI | M_RD);
    repeat (10) @(negedge clk);
    card_err = 1'b1; @(negedge clk); card_err = 1'b0;
    rd(S_STAT, v); check("R10 error bit only", v, 32'h8000);
    quiet(20, "R10 stopped");
    wr(S_STAT, 32'h8000); rd(S_STAT, v); check("R9 error cleared", v, 32'h0);

    // R12 writes ignored while moving
    setup(32'h3000, bsz(7, 20), 32'h0);
    wr(S_MODE, M_DMA);
    repeat (3) @(negedge clk);
    wr(S_BSIZE, bsz(7, 4)); wr(S_ADDR, 32'h5000); wr(S_BCNT, 32'd9); wr(S_HCTL, 32'h18);
    wait_stat(32'h2);
    repeat (2) @(negedge clk);
    rd(S_BSIZE, v); check("R12 size kept", v, bsz(7, 20));
    rd(S_ADDR, v); check("R12 addr kept", v, 32'h3014);
    rd(S_HCTL, v); check("R12 hctl kept", v, 32'h0);
    rd(S_BCNT, v); check("R12 count kept", v, 32'h0);
    check("R12 bytes sent", 32'(tx_idx), 32'd20);
    wr(S_STAT, 32'hFFFF);

    // random transfers
    for (int it = 0; it < 8; it++) begin
      int sz, nb, dir, bad;
      logic [31:0] a, md;
      sz  = 1 + int'($urandom % 24);
      nb  = 1 + int'($urandom % 3);
      dir = int'($urandom % 2);
      a   = 32'h4000 + ($urandom % 32'h3000);
      setup(a, bsz(7, sz), 32'(nb));
      md = M_DMA | (dir != 0 ? M_RD : 32'h0) | (nb > 1 ? (M_CNT | M_MULTI) : 32'h0);
      wr(S_MODE, md);
      wait_stat(32'h2);
      repeat (2) @(negedge clk);
      bad = 0;
      if (dir != 0) begin
        for (int i = 0; i < sz * nb; i++) if (mem_m[16'(a + 32'(i))] !== rx_seq[i]) bad++;
        check("R3 random read", 32'(bad), 32'd0);
      end else begin
        check("R4 random count", 32'(tx_idx), 32'(sz * nb));
        for (int i = 0; i < sz * nb; i++) if (tx_cap[i] !== pat(a + 32'(i))) bad++;
        check("R4 random write", 32'(bad), 32'd0);
      end
      rd(S_ADDR, v); check("R7 random end addr", v, a + 32'(sz * nb));
      wr(S_STAT, 32'hFFFF);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL R1 watchdog act=running exp=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule